// File: doc/BRIEF.md
# Ripple-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic-logic unit for two signed or unsigned operands, four bits wide by default. A 4-bit operation code selects one of five functions: bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison. It returns a result word and three flags: carry-out, signed overflow and a zero flag. The zero flag is the equality test after a subtraction.

The datapath is a chain of identical one-bit slices. The carry ripples from the least significant slice upward. Subtraction uses the same adder: each slice XORs its B bit with a shared invert control, and the same control drives the carry into bit 0. The less-than result comes from the top slice. Its comparison bit is routed back to the "less" input of slice 0. Every other slice has its less input tied low, so the comparison result appears as 1 or 0 in the result word.

The unit holds no state. A datapath or CPU model instantiates it between its register read ports and its write-back path.

Top module: `alu4_top`

## Requirements
- R1: With op = 4'b0000 the result is the bitwise AND of a and b.
- R2: With op = 4'b0001 the result is the bitwise OR of a and b.
- R3: With op = 4'b0010 the result is (a + b) modulo 2^WIDTH, and carry_out is the unsigned carry out of the top bit.
- R4: With op = 4'b0110 the result is (a + ~b + 1) modulo 2^WIDTH, which equals a - b. carry_out is the carry out of the top bit of that sum, so it is 1 exactly when a >= b as unsigned values.
- R5: For add and subtract, overflow is 1 exactly when the two's-complement result of the signed operation falls outside the range of a WIDTH-bit signed number.
- R6: With op = 4'b0111 the result is 1 (all upper bits 0) when a < b as two's-complement numbers, and 0 otherwise. This holds even when a - b overflows.
- R7: For AND, OR and set-on-less-than, carry_out and overflow are both 0.
- R8: The zero output is 1 exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 4 | Operation code: 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 set-on-less-than |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry out of the top slice, for add and subtract only |
| overflow | output | 1 | Signed overflow, for add and subtract only |
| zero | output | 1 | High when the result is all zeros |

## Verification
The bench builds the unit with WIDTH at its default of 4. At that width the full cross product of operands and the five operation codes is only 1280 vectors, so every operand pair is applied under every function. This reaches every signed-overflow corner. Examples are the most negative value minus a positive value, and the less-than comparisons whose internal subtraction overflows. It also reaches every carry and borrow pattern through the ripple chain. A few named corner vectors are checked before the sweep so that the comparison-through-overflow cases and the equal-operand subtraction are reported separately.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    // Operation codes; bit 2 drives B inversion and carry-in together.
    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    // Per-slice output selection, taken from the low two opcode bits.
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } alu_flags_t;

    function automatic logic op_inverts_b(logic [3:0] op);
        return op[2];
    endfunction

    function automatic slice_sel_e op_slice_sel(logic [3:0] op);
        return slice_sel_e'(op[1:0]);
    endfunction

    function automatic logic op_is_arith(logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       binv_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    logic b_eff;
    logic half;

    always_comb begin
        b_eff  = b_i ^ binv_i;
        half   = a_i ^ b_eff;
        sum_o  = half ^ cin_i;
        cout_o = (a_i & b_eff) | (cin_i & half);
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_eff;
            SEL_OR:   res_o = a_i | b_eff;
            SEL_SUM:  res_o = sum_o;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu4_msb_flags.sv
module alu4_msb_flags (
    input  logic sum_msb_i,
    input  logic cin_msb_i,
    input  logic cout_msb_i,
    output logic set_o,
    output logic ovf_o
);

    // Signed overflow from the carries around the top slice; the
    // comparison bit corrects the sign for an overflowed subtraction.
    always_comb begin
        ovf_o = cin_msb_i ^ cout_msb_i;
        set_o = sum_msb_i ^ ovf_o;
    end

endmodule

// File: rtl/alu4_zero_detect.sv
module alu4_zero_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             zero_o
);

    always_comb zero_o = ~|value_i;

endmodule

// File: rtl/alu4_top.sv
module alu4_top
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);

    localparam int MSB = WIDTH - 1;

    logic             binv;
    slice_sel_e       sel;
    logic             set_w;
    logic             ovf_raw;
    logic [WIDTH-1:0] result_w;
    logic             zero_w;
    alu_flags_t       flags;

    assign binv = op_inverts_b(op);
    assign sel  = op_slice_sel(op);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin;
        logic less;
        logic res_b;
        logic sum_b;
        logic cout_b;

        if (i == 0) begin : g_lsb
            assign cin  = binv;
            assign less = set_w;
        end else begin : g_upper
            assign cin  = g_bit[i-1].cout_b;
            assign less = 1'b0;
        end

        alu4_slice u_slice (
            .a_i    (a[i]),
            .b_i    (b[i]),
            .binv_i (binv),
            .cin_i  (cin),
            .less_i (less),
            .sel_i  (sel),
            .res_o  (res_b),
            .sum_o  (sum_b),
            .cout_o (cout_b)
        );

        assign result_w[i] = res_b;
    end

    alu4_msb_flags u_msb (
        .sum_msb_i  (g_bit[MSB].sum_b),
        .cin_msb_i  (g_bit[MSB].cin),
        .cout_msb_i (g_bit[MSB].cout_b),
        .set_o      (set_w),
        .ovf_o      (ovf_raw)
    );

    alu4_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value_i (result_w),
        .zero_o  (zero_w)
    );

    always_comb begin
        flags.carry = op_is_arith(op) & g_bit[MSB].cout_b;
        flags.ovf   = op_is_arith(op) & ovf_raw;
        flags.zero  = zero_w;
    end

    assign result    = result_w;
    assign carry_out = flags.carry;
    assign overflow  = flags.ovf;
    assign zero      = flags.zero;

    always_comb begin
        // R6
        slt_form_chk: assert (op != OP_SLT || result[MSB:1] == '0);
        // R7
        logic_flags_chk: assert (!(op == OP_AND || op == OP_OR || op == OP_SLT)
                                 || (!carry_out && !overflow));
        // R8
        zero_flag_chk: assert (!zero || result == '0);
        // R4
        sub_equal_chk: assert (op != OP_SUB || a != b || (zero && carry_out));
        // R5
        add_ovf_sign_chk: assert (op != OP_ADD || !overflow
                                  || (a[MSB] == b[MSB] && result[MSB] != a[MSB]));
    end

endmodule

// File: tb/test_alu4_top.sv
module test_alu4_top;

    localparam int WIDTH = 4;
    localparam int SPAN  = 1 << WIDTH;

    logic             clk = 1'b0;
    logic [WIDTH-1:0] a = '0;
    logic [WIDTH-1:0] b = '0;
    logic [3:0]       op = 4'b0000;
    logic [WIDTH-1:0] result;
    logic             carry_out;
    logic             overflow;
    logic             zero;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu4_top #(.WIDTH(WIDTH)) i_alu4_top (
        .a(a), .b(b), .op(op),
        .result(result), .carry_out(carry_out),
        .overflow(overflow), .zero(zero)
    );

    function automatic int to_signed(int v);
        return (v >= SPAN / 2) ? v - SPAN : v;
    endfunction

    function automatic logic [3:0] op_code(int k);
        case (k)
            0: return 4'b0000;
            1: return 4'b0001;
            2: return 4'b0010;
            3: return 4'b0110;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic string op_req(logic [3:0] o);
        case (o)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3/R5";
            4'b0110: return "R4/R5";
            default: return "R6";
        endcase
    endfunction

    // Behavioural reference built from the requirements.
    task automatic model(input int av, input int bv, input logic [3:0] o,
                         output int er, output int ec, output int ev);
        int sa = to_signed(av);
        int sb = to_signed(bv);
        int full;
        int sres;
        er = 0; ec = 0; ev = 0;
        case (o)
            4'b0000: er = av & bv;
            4'b0001: er = av | bv;
            4'b0010: begin
                full = av + bv;
                er = full % SPAN; ec = full / SPAN;
                sres = sa + sb;
                ev = (sres > SPAN/2 - 1 || sres < -SPAN/2) ? 1 : 0;
            end
            4'b0110: begin
                full = av + (SPAN - 1 - bv) + 1;
                er = full % SPAN; ec = full / SPAN;
                sres = sa - sb;
                ev = (sres > SPAN/2 - 1 || sres < -SPAN/2) ? 1 : 0;
            end
            default: er = (sa < sb) ? 1 : 0;
        endcase
    endtask

    task automatic apply_check(input int av, input int bv, input logic [3:0] o,
                               input string tag);
        int er, ec, ev, ez;
        @(posedge clk);
        #1;
        a = WIDTH'(av); b = WIDTH'(bv); op = o;
        @(negedge clk);
        model(av, bv, o, er, ec, ev);
        ez = (er == 0) ? 1 : 0;
        n_checks++;
        if (int'(result) != er || int'(carry_out) != ec
            || int'(overflow) != ev || int'(zero) != ez) begin
            n_fail++;
            $display("FAIL %s (%s) op=%b a=%0d b=%0d: got res=%0d c=%0d v=%0d z=%0d exp res=%0d c=%0d v=%0d z=%0d (R7 R8 flags)",
                     tag, op_req(o), o, av, bv, result, carry_out, overflow, zero,
                     er, ec, ev, ez);
        end
    endtask

    initial begin
        // Idle state with all inputs low: AND of zeros, R8 zero flag high
        apply_check(0, 0, 4'b0000, "R1 idle R8");
        // R6: 7 < -8 is false although 7 - (-8) overflows
        apply_check(7, 8, 4'b0111, "R6 overflowed compare false");
        // R6: -8 < 7 is true although -8 - 7 overflows
        apply_check(8, 7, 4'b0111, "R6 overflowed compare true");
        // R4: equal operands give zero with carry set
        apply_check(5, 5, 4'b0110, "R4 equal operands R8");
        // R4: borrow case clears carry
        apply_check(3, 9, 4'b0110, "R4 borrow");
        // R5: positive + positive overflow
        apply_check(7, 1, 4'b0010, "R5 add overflow");
        // R3: unsigned carry, wraps to zero
        apply_check(15, 1, 4'b0010, "R3 wrap carry R8");
        // R7: logic ops keep flags low on all-ones
        apply_check(15, 15, 4'b0001, "R7 or flags");
        apply_check(15, 15, 4'b0000, "R7 and flags");
        // R2: disjoint bits
        apply_check(10, 5, 4'b0001, "R2 disjoint");
        // Full sweep of every operand pair and every opcode
        for (int k = 0; k < 5; k++)
            for (int x = 0; x < SPAN; x++)
                for (int y = 0; y < SPAN; y++)
                    apply_check(x, y, op_code(k), "sweep");
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles exp completion", cycles);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule